// File: doc/BRIEF.md
# Live-Insertion Two-Wire Bus Link Controller

This block decides when a plug-in card's two-wire bus segment (data and clock) may be tied to the matching segment on a powered backplane. Once the two are tied, it repeats lows between them. Each line is seen only as a logic level sampled through a synchronizer. Each side of each line is driven only through an open-drain pull-down enable. A power-good input holds the block in lockout while the supply is low. While in lockout, nothing on the bus has any effect.

When the supply comes up, the card may have landed in the middle of a backplane transfer. The block therefore waits for a transfer boundary on the backplane side. That boundary is either a STOP, or both backplane lines staying high for a set number of cycles. The block then also waits until both card lines read high. It then joins the segments and raises a ready flag. While joined, it acts as a symmetric wired-AND: a low on either side is copied to the other side. A line goes high again only when every driver on both sides has let go. Per-line bookkeeping of which side the block itself is pulling stops the block from latching a line low through its own pull-downs.

A disconnect request from an outside watchdog drops the link at once. The block then waits for a fresh boundary before it joins again.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While `pwrGood` is low, all four pull-down enables are low in that same cycle and `ready` is low from the next clock. Neither a STOP nor an idle bus seen during lockout counts toward joining. After `pwrGood` rises, the block needs a new boundary before it joins.
- R2: A STOP is a low-to-high change of synchronized backplane SDA while synchronized backplane SCL is high. A STOP arms the join without waiting for the idle count.
- R3: An idle bus is `IDLE_CYCLES` consecutive synchronized samples with both backplane lines high. It arms the join. A shorter run of high samples does not.
- R4: The join takes place only in a cycle where the synchronized card SDA and card SCL are both high. An armed block keeps waiting, still armed, until that is true.
- R5: `ready` is high exactly while the segments are joined. Three clock edges after the edge that samples a STOP, `ready` reads high, provided the card lines are high.
- R6: While joined, an outside low on one side of a line turns on the pull-down for the other side of that same line within `SYNC_STAGES`+1 clocks.
- R7: While joined, a line held low from both sides stays low on both sides after either side alone lets go. It rises on both sides only after both sides have let go.
- R8: Once every outside driver has let go of a joined line, the block releases both pull-downs of that line within a bounded number of cycles and does not drive it again.
- R9: An asserted `discReq` turns off every pull-down in the same cycle and drops `ready` at the next clock. The block then waits for a new STOP or idle bus.
- R10: After reset, `ready` and all pull-down enables are low and the block is in lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Supply above the lockout threshold |
| discReq | input | 1 | Disconnect request from an outside watchdog |
| bpSdaIn | input | 1 | Sampled level of backplane SDA |
| bpSclIn | input | 1 | Sampled level of backplane SCL |
| cdSdaIn | input | 1 | Sampled level of card SDA |
| cdSclIn | input | 1 | Sampled level of card SCL |
| bpSdaPd | output | 1 | Pull-down enable for backplane SDA |
| bpSclPd | output | 1 | Pull-down enable for backplane SCL |
| cdSdaPd | output | 1 | Pull-down enable for card SDA |
| cdSclPd | output | 1 | Pull-down enable for card SCL |
| ready | output | 1 | Segments joined |

## Verification
The bench builds the block with `IDLE_CYCLES` set to 12 and `SYNC_STAGES` left at 2. This makes the idle path short enough to test both a run one short of the limit and a complete run. A STOP-triggered join can then be told apart from an idle-triggered one by its timing alone. The bench models the lines as wired-AND nets between its own open-drain drivers and the block's pull-downs. With the short idle limit, it can also test the handoff cases, such as both sides low followed by a one-sided release, and a disconnect or power loss while a pull-down is active.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

  // Top-level link phases
  typedef enum logic [1:0] {
    LINK_LOCKOUT = 2'd0,
    LINK_WAIT    = 2'd1,
    LINK_JOINED  = 2'd2
  } linkState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic linkOn;    // segments joined
    logic forceRel;  // drop every pull-down now
  } linkCtl_t;

  // Per-line repeater phases
  typedef enum logic [2:0] {
    LN_FREE   = 3'd0,  // nobody driven by us
    LN_DRV_CD = 3'd1,  // backplane low seen, card pulled
    LN_CHK_CD = 3'd2,  // backplane let go: hold backplane, probe card
    LN_DRV_BP = 3'd3,  // card low seen, backplane pulled
    LN_CHK_BP = 3'd4   // card let go: hold card, probe backplane
  } lineState_e;

  localparam int LINE_COUNT = 2;  // index 0 = SDA, 1 = SCL

endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  // lines idle high, so stages reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/hsl_ctrl.sv
module hsl_ctrl
  import hsl_pkg::*;
#(
  parameter int IDLE_CYCLES = 1000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwrGood,
  input  logic     discReq,
  input  logic     bpSda,
  input  logic     bpScl,
  input  logic     cdSda,
  input  logic     cdScl,
  output linkCtl_t ctl,
  output logic     ready
);

  localparam int CNT_W = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYCLES - 1);

  linkState_e       state;
  logic             armed;
  logic [CNT_W-1:0] idleCnt;
  logic             sdaPrev;

  logic stopEvt, busHigh, idleHit, boundary, cardHigh;

  assign busHigh  = bpSda && bpScl;
  assign stopEvt  = !sdaPrev && bpSda && bpScl;
  assign idleHit  = busHigh && (idleCnt == IDLE_LAST);
  assign boundary = stopEvt || idleHit;
  assign cardHigh = cdSda && cdScl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= LINK_LOCKOUT;
      armed   <= 1'b0;
      idleCnt <= '0;
      sdaPrev <= 1'b1;
    end else begin
      sdaPrev <= bpSda;
      if (!pwrGood) begin
        state   <= LINK_LOCKOUT;
        armed   <= 1'b0;
        idleCnt <= '0;
      end else if (state == LINK_LOCKOUT || discReq) begin
        state   <= LINK_WAIT;
        armed   <= 1'b0;
        idleCnt <= '0;
      end else if (state == LINK_WAIT) begin
        if (!busHigh)              idleCnt <= '0;
        else if (idleCnt != IDLE_LAST) idleCnt <= idleCnt + CNT_W'(1);
        if ((armed || boundary) && cardHigh) begin
          state <= LINK_JOINED;
          armed <= 1'b0;
        end else begin
          armed <= armed || boundary;
        end
      end else begin
        idleCnt <= '0;
      end
    end
  end

  assign ready        = (state == LINK_JOINED);
  assign ctl.linkOn   = (state == LINK_JOINED);
  assign ctl.forceRel = !pwrGood || discReq;

  // R1
  lockout_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrGood |=> !ready);

  // R9
  disc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discReq |=> !ready);

  // R4
  card_high_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(cdSda && cdScl));

  // R2 R3
  join_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(armed || stopEvt || idleHit));

endmodule

// File: rtl/hsl_datapath.sv
module hsl_datapath
  import hsl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LINES       = LINE_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  linkCtl_t         ctl,
  input  logic [LINES-1:0] bpIn,
  input  logic [LINES-1:0] cdIn,
  output logic [LINES-1:0] bpPd,
  output logic [LINES-1:0] cdPd
);

  localparam int BW = $clog2(SYNC_STAGES + 1);
  localparam logic [BW-1:0] BLANK = BW'(SYNC_STAGES);

  logic gateOn;
  assign gateOn = ctl.linkOn && !ctl.forceRel;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    lineState_e     st;
    logic [BW-1:0]  blank;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st    <= LN_FREE;
        blank <= '0;
      end else if (!gateOn) begin
        st    <= LN_FREE;
        blank <= '0;
      end else begin
        unique case (st)
          LN_FREE: begin
            if (blank != '0)  blank <= blank - BW'(1);
            else if (!bpIn[g]) st   <= LN_DRV_CD;
            else if (!cdIn[g]) st   <= LN_DRV_BP;
          end
          LN_DRV_CD: if (bpIn[g]) begin
            st    <= LN_CHK_CD;
            blank <= BLANK;
          end
          LN_CHK_CD: begin
            if (blank != '0)   blank <= blank - BW'(1);
            else if (!cdIn[g]) st    <= LN_DRV_BP;
            else begin
              st    <= LN_FREE;
              blank <= BLANK;
            end
          end
          LN_DRV_BP: if (cdIn[g]) begin
            st    <= LN_CHK_BP;
            blank <= BLANK;
          end
          LN_CHK_BP: begin
            if (blank != '0)   blank <= blank - BW'(1);
            else if (!bpIn[g]) st    <= LN_DRV_CD;
            else begin
              st    <= LN_FREE;
              blank <= BLANK;
            end
          end
          default: st <= LN_FREE;
        endcase
      end
    end

    assign cdPd[g] = gateOn && (st == LN_DRV_CD || st == LN_CHK_BP);
    assign bpPd[g] = gateOn && (st == LN_DRV_BP || st == LN_CHK_CD);

    // R6
    follow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gateOn && st == LN_FREE && blank == '0 && !bpIn[g]) |=> (st == LN_DRV_CD));

    // R8
    let_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LN_DRV_CD && bpIn[g]) |=> !cdPd[g]);
  end

endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl
  import hsl_pkg::*;
#(
  parameter int IDLE_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrGood,
  input  logic discReq,
  input  logic bpSdaIn,
  input  logic bpSclIn,
  input  logic cdSdaIn,
  input  logic cdSclIn,
  output logic bpSdaPd,
  output logic bpSclPd,
  output logic cdSdaPd,
  output logic cdSclPd,
  output logic ready
);

  logic [3:0] syncOut;
  linkCtl_t   ctl;
  logic [LINE_COUNT-1:0] bpPdVec, cdPdVec;

  hsl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bpSdaIn, bpSclIn, cdSdaIn, cdSclIn}),
    .dout (syncOut)
  );

  hsl_ctrl #(.IDLE_CYCLES(IDLE_CYCLES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwrGood(pwrGood),
    .discReq(discReq),
    .bpSda  (syncOut[3]),
    .bpScl  (syncOut[2]),
    .cdSda  (syncOut[1]),
    .cdScl  (syncOut[0]),
    .ctl    (ctl),
    .ready  (ready)
  );

  hsl_datapath #(.SYNC_STAGES(SYNC_STAGES), .LINES(LINE_COUNT)) u_dp (
    .clk  (clk),
    .rst_n(rst_n),
    .ctl  (ctl),
    .bpIn ({syncOut[2], syncOut[3]}),
    .cdIn ({syncOut[0], syncOut[1]}),
    .bpPd (bpPdVec),
    .cdPd (cdPdVec)
  );

  assign bpSdaPd = bpPdVec[0];
  assign bpSclPd = bpPdVec[1];
  assign cdSdaPd = cdPdVec[0];
  assign cdSclPd = cdPdVec[1];

  // R1 R9
  no_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwrGood || discReq) |-> !(bpSdaPd || bpSclPd || cdSdaPd || cdSclPd));

  // R5
  pd_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bpSdaPd || bpSclPd || cdSdaPd || cdSclPd) |-> ready);

endmodule

// File: tb/hotswap_link_ctrl_bench.sv
module hotswap_link_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE       = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrGood = 1'b0, discReq = 1'b0;
  logic extBpSda = 1'b0, extBpScl = 1'b0, extCdSda = 1'b0, extCdScl = 1'b0;
  logic bpSdaPd, bpSclPd, cdSdaPd, cdSclPd, ready;
  logic bpSda, bpScl, cdSda, cdScl;

  // wired-AND nets: ext* = 1 means an outside device pulls low
  assign bpSda = ~(extBpSda | bpSdaPd);
  assign bpScl = ~(extBpScl | bpSclPd);
  assign cdSda = ~(extCdSda | cdSdaPd);
  assign cdScl = ~(extCdScl | cdSclPd);

  hotswap_link_ctrl #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) u_hotswap_link_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrGood(pwrGood), .discReq(discReq),
    .bpSdaIn(bpSda), .bpSclIn(bpScl), .cdSdaIn(cdSda), .cdSclIn(cdScl),
    .bpSdaPd(bpSdaPd), .bpSclPd(bpSclPd), .cdSdaPd(cdSdaPd), .cdSclPd(cdSclPd),
    .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference of the link phase: 0 lockout, 1 wait, 2 joined
  logic [3:0] hist[$];
  int mState = 0;
  bit mArmed = 0;
  int mCnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 0; mArmed = 0; mCnt = 0;
      hist = '{4'hF, 4'hF, 4'hF, 4'hF};
    end else begin
      logic [3:0] s2, s3;
      bit busHi, evt;
      hist.push_front({bpSda, bpScl, cdSda, cdScl});
      void'(hist.pop_back());
      s2 = hist[2];
      s3 = hist[3];
      if (!pwrGood) begin
        mState = 0; mArmed = 0; mCnt = 0;
      end else if (mState == 0 || discReq) begin
        mState = 1; mArmed = 0; mCnt = 0;
      end else if (mState == 1) begin
        busHi = s2[3] && s2[2];
        evt = (!s3[3] && s2[3] && s2[2]) || (busHi && mCnt == IDLE - 1);
        mCnt = busHi ? ((mCnt < IDLE - 1) ? mCnt + 1 : mCnt) : 0;
        if ((mArmed || evt) && s2[1] && s2[0]) begin
          mState = 2; mArmed = 0;
        end else begin
          mArmed = mArmed || evt;
        end
      end else begin
        mCnt = 0;
      end
    end
  end

  // every-clock comparison
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      // R5 ready mirrors the join state
      chk(ready == (mState == 2), "R5 ready vs model", ready, mState == 2);
      // R1 R9 no pull-down unless joined and allowed
      if (mState != 2 || !pwrGood || discReq)
        chk({bpSdaPd, bpSclPd, cdSdaPd, cdSclPd} == 4'b0, "R1/R9 pull-downs off",
            {bpSdaPd, bpSclPd, cdSdaPd, cdSclPd}, 0);
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(ready == 0, "R10 ready after reset", ready, 0);
    chk({bpSdaPd, bpSclPd, cdSdaPd, cdSclPd} == 0, "R10 pd after reset",
        {bpSdaPd, bpSclPd, cdSdaPd, cdSclPd}, 0);

    // R1 activity during lockout: STOPs and a long idle are ignored
    tick(1);
    for (int i = 0; i < 3; i++) begin
      extBpSda = 1'b1; tick(2);
      extBpSda = 1'b0; tick(2);
    end
    tick(IDLE + 5);
    chk(ready == 0, "R1 ready during lockout", ready, 0);

    // power up into a busy bus: SDA held low, SCL toggling
    extBpSda = 1'b1;
    pwrGood  = 1'b1;
    for (int i = 0; i < 8; i++) begin
      extBpScl = ~extBpScl; tick(2);
    end
    extBpScl = 1'b0;
    tick(2);
    // R1 R2 no boundary yet
    chk(ready == 0, "R2 no join before STOP", ready, 0);

    // R4 STOP with card SCL low: armed but not joined
    extCdScl = 1'b1;
    tick(1);
    extBpSda = 1'b0;  // STOP
    tick(6);
    chk(ready == 0, "R4 card low blocks join", ready, 0);
    extCdScl = 1'b0;
    tick(5);
    chk(ready == 1, "R4 join after card high", ready, 1);

    // R6 backplane SDA low copied to card
    extBpSda = 1'b1; tick(6);
    chk(cdSda == 0, "R6 card SDA follows", cdSda, 0);
    chk(cdSdaPd == 1, "R6 card SDA pd on", cdSdaPd, 1);
    extBpSda = 1'b0; tick(10);
    chk(bpSda == 1 && cdSda == 1, "R8 SDA released", {bpSda, cdSda}, 3);

    // R6 card SCL low copied to backplane
    extCdScl = 1'b1; tick(6);
    chk(bpScl == 0, "R6 backplane SCL follows", bpScl, 0);
    extCdScl = 1'b0; tick(10);
    chk(bpScl == 1 && cdScl == 1, "R8 SCL released", {bpScl, cdScl}, 3);

    // R7 both sides low, release one side, then the other
    extBpSda = 1'b1; tick(6);
    extCdSda = 1'b1; tick(4);
    extBpSda = 1'b0; tick(10);
    chk(bpSda == 0 && cdSda == 0, "R7 held low by card", {bpSda, cdSda}, 0);
    extCdSda = 1'b0; tick(12);
    chk(bpSda == 1 && cdSda == 1, "R7 rises after both let go", {bpSda, cdSda}, 3);
    tick(20);
    // R8 no latch-up
    chk({bpSdaPd, bpSclPd, cdSdaPd, cdSclPd} == 0, "R8 no latch-up",
        {bpSdaPd, bpSclPd, cdSdaPd, cdSclPd}, 0);
    chk(ready == 1, "R5 still joined", ready, 1);

    // R9 disconnect while a pull-down is active
    extBpSda = 1'b1; tick(6);
    chk(cdSdaPd == 1, "R9 pd active before request", cdSdaPd, 1);
    discReq = 1'b1;
    #1;
    chk(cdSdaPd == 0, "R9 pd off at once", cdSdaPd, 0);
    tick(1);
    chk(ready == 0, "R9 ready dropped", ready, 0);
    extBpSda = 1'b0;  // STOP while request held: ignored
    tick(4);
    discReq = 1'b0;
    // R3 idle run shorter than the limit
    tick(IDLE - 4);
    chk(ready == 0, "R3 short idle no join", ready, 0);
    tick(8);
    chk(ready == 1, "R3 idle join", ready, 1);

    // R2 quick STOP join, faster than the idle limit
    discReq = 1'b1; extBpSda = 1'b1; tick(3);
    discReq = 1'b0;
    for (int i = 0; i < 4; i++) begin
      extBpScl = ~extBpScl; tick(2);
    end
    extBpScl = 1'b0; tick(2);
    chk(ready == 0, "R2 waiting for STOP", ready, 0);
    extBpSda = 1'b0;
    tick(4);
    chk(ready == 1, "R2 STOP join", ready, 1);

    // R1 power loss while joined and driving
    extCdScl = 1'b1; tick(6);
    chk(bpSclPd == 1, "R6 backplane SCL pd on", bpSclPd, 1);
    pwrGood = 1'b0;
    #1;
    chk(bpSclPd == 0, "R1 pd off on power loss", bpSclPd, 0);
    tick(1);
    chk(ready == 0, "R1 ready off on power loss", ready, 0);
    extCdScl = 1'b0; tick(3);
    pwrGood = 1'b1; tick(2);
    chk(ready == 0, "R1 waits after power return", ready, 0);
    tick(IDLE + 6);
    chk(ready == 1, "R3 rejoin by idle", ready, 1);

    tick(2);
    finish_run();
  end

endmodule